// File: doc/BRIEF.md
# Power-over-Ethernet Port Mode Sequencer

This block is the control state machine for one powered Ethernet port. A 2-bit mode input decides how far the port goes without host help: it stays dark, waits for a host power command, runs detection and classification but never powers, or runs the full sequence up to turn-on. The measurements themselves are made elsewhere. The sequencer raises one request at a time (detection, classification event, mark phase) and takes back a done strobe with a result code. When the sequence finishes it raises the power enable.

In auto mode a first result of class 4 starts a two-event exchange: mark, second classification event, second mark. Power follows only if the second event also reports class 4. Otherwise the port records a classification error and goes back to detection. Auto mode also sets the cut-current code from the class result and the high-power flag. The flag is latched when power turns on and selects the DC current limit (425 mA or 850 mA nominal).

Top module: `poe_port_seq`

## Requirements
- R1: After reset every request output and pwr_en_o are 0, det_stat_o and cls_stat_o are 0 (unknown), icut_o is 114 and ilim_hi_o is 0.
- R2: With mode 00 (shutdown) the block issues no detection, classification or mark request and keeps power off; man_pwr_i and result strobes have no effect.
- R3: A mode change takes the port back to idle with power off on the next cycle. A change to 00 also returns det_stat_o and cls_stat_o to 0.
- R4: In mode 10 or 11 the idle port raises det_req_o on the next cycle. A det_done_i strobe copies det_res_i into det_stat_o. Any result other than 4 (good) returns the port to idle without a classification request.
- R5: A detection result of 4 raises cls_req_o on the next cycle. Classification never starts in modes 10 or 11 without a good detection.
- R6: In mode 10, after classification the port parks with no request and no power until the mode changes, and icut_o is not updated.
- R7: In mode 11 a first classification result of class 0 to 3 turns pwr_en_o on in the next cycle.
- R8: In mode 11 a first result of class 4 raises mark_req_o, then cls_req_o for the second event, then mark_req_o again. Power turns on after the second mark_done_i only if the second result was class 4.
- R9: If the second result is not class 4, cls_stat_o becomes 6, cls_err_o is 1, power stays off and the port returns to detection.
- R10: In mode 01, man_pwr_i starts one classification event. Its done strobe turns power on whatever the class, and icut_o is unchanged.
- R11: When power turns on in mode 11, icut_o becomes 29, 51, 114 or 196: class 1 → 29, class 2 → 51, class 4 with hp_i=1 → 196, all other cases → 114 (3.2 mA steps). cls_stat_o holds class number plus 1.
- R12: ilim_hi_o takes hp_i in the cycle power turns on and ignores later changes of hp_i.
- R13: disc_i while powered turns power off on the next cycle and returns both status outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 00 shutdown, 01 manual, 10 semi-auto, 11 auto |
| hp_i | input | 1 | High-power flag |
| man_pwr_i | input | 1 | Manual power command strobe |
| det_done_i | input | 1 | Detection complete strobe |
| det_res_i | input | 3 | Detection result, 4 = good |
| cls_done_i | input | 1 | Classification event complete strobe |
| cls_res_i | input | 3 | Class number 0 to 4 |
| mark_done_i | input | 1 | Mark phase complete strobe |
| disc_i | input | 1 | Disconnect / port shutdown event |
| det_req_o | output | 1 | Run detection |
| cls_req_o | output | 1 | Run a classification event |
| mark_req_o | output | 1 | Run a mark phase |
| pwr_en_o | output | 1 | Port power enable |
| det_stat_o | output | 3 | Last detection result, 0 unknown |
| cls_stat_o | output | 3 | Last class plus 1, 0 unknown, 6 error |
| cls_err_o | output | 1 | Classification error flag |
| icut_o | output | ICUT_W | Cut-current code |
| ilim_hi_o | output | 1 | High current limit selected |

## Verification
On every cycle the assertions check the following:
- At most one of the three requests and the power enable is active.
- Shutdown and semi-auto never leave power on.
- Power rises only from manual or auto mode, with a class result already recorded.
- A classification error never coexists with power.
- icut_o only moves after an auto-mode cycle.

Only the bench scenarios can show the rest: the exact order of the two-event exchange, the cut-current code for each class and flag combination, the latching of the current limit, and the status clearing on shutdown or disconnect. The bench covers these by sweeping every class pair, flag value and mode.

// File: rtl/poe_seq_pkg.sv
package poe_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE, ST_DET, ST_CLS1, ST_MRK1, ST_CLS2, ST_MRK2, ST_PARK, ST_PWR
   } seq_st_e;

   localparam logic [1:0] MD_OFF  = 2'b00;
   localparam logic [1:0] MD_MAN  = 2'b01;
   localparam logic [1:0] MD_SEMI = 2'b10;
   localparam logic [1:0] MD_AUTO = 2'b11;

   localparam logic [2:0] DET_UNK  = 3'd0;
   localparam logic [2:0] DET_GOOD = 3'd4;
   localparam logic [2:0] CLS_UNK  = 3'd0;
   localparam logic [2:0] CLS_ERR  = 3'd6;
   localparam logic [2:0] CLS_FOUR = 3'd4;

   // status code for a class number: number plus one, zero kept for unknown
   function automatic logic [2:0] cls_code(input logic [2:0] num);
      return num + 3'd1;
   endfunction

endpackage

// File: rtl/poe_mode_track.sv
module poe_mode_track
   import poe_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode_i,
   output logic       chg_o,
   output logic       to_off_o
);

   logic [1:0] mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= MD_OFF;
      else        mode_q <= mode_i;
   end

   assign chg_o    = (mode_i != mode_q);
   assign to_off_o = chg_o && (mode_i == MD_OFF);

endmodule

// File: rtl/poe_seq_fsm.sv
module poe_seq_fsm
   import poe_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode_i,
   input  logic       chg_i,
   input  logic       to_off_i,
   input  logic       man_pwr_i,
   input  logic       det_done_i,
   input  logic [2:0] det_res_i,
   input  logic       cls_done_i,
   input  logic [2:0] cls_res_i,
   input  logic       mark_done_i,
   input  logic       disc_i,
   output seq_st_e    st_o,
   output logic       det_wr_o,
   output logic       cls_wr_o,
   output logic [2:0] cls_val_o,
   output logic       icut_upd_o,
   output logic [2:0] icut_cls_o,
   output logic       pwr_enter_o,
   output logic       shut_o
);

   seq_st_e st_q, st_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   always_comb begin
      st_d        = st_q;
      det_wr_o    = 1'b0;
      cls_wr_o    = 1'b0;
      cls_val_o   = CLS_UNK;
      icut_upd_o  = 1'b0;
      icut_cls_o  = cls_res_i;
      pwr_enter_o = 1'b0;
      shut_o      = 1'b0;
      if (chg_i) begin
         st_d   = ST_IDLE;
         shut_o = to_off_i;
      end else if (mode_i == MD_OFF) begin
         st_d = ST_IDLE;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (mode_i == MD_AUTO || mode_i == MD_SEMI) st_d = ST_DET;
               else if (man_pwr_i)                         st_d = ST_CLS1;
            end
            ST_DET: begin
               if (det_done_i) begin
                  det_wr_o = 1'b1;
                  st_d     = (det_res_i == DET_GOOD) ? ST_CLS1 : ST_IDLE;
               end
            end
            ST_CLS1: begin
               if (cls_done_i) begin
                  cls_wr_o  = 1'b1;
                  cls_val_o = cls_code(cls_res_i);
                  if (mode_i == MD_SEMI) begin
                     st_d = ST_PARK;
                  end else if (mode_i == MD_AUTO && cls_res_i == CLS_FOUR) begin
                     st_d = ST_MRK1;
                  end else begin
                     st_d        = ST_PWR;
                     pwr_enter_o = 1'b1;
                     icut_upd_o  = (mode_i == MD_AUTO);
                  end
               end
            end
            ST_MRK1: if (mark_done_i) st_d = ST_CLS2;
            ST_CLS2: begin
               if (cls_done_i) begin
                  cls_wr_o = 1'b1;
                  if (cls_res_i == CLS_FOUR) begin
                     cls_val_o = cls_code(CLS_FOUR);
                     st_d      = ST_MRK2;
                  end else begin
                     cls_val_o = CLS_ERR;
                     st_d      = ST_IDLE;
                  end
               end
            end
            ST_MRK2: begin
               icut_cls_o = CLS_FOUR;
               if (mark_done_i) begin
                  st_d        = ST_PWR;
                  pwr_enter_o = 1'b1;
                  icut_upd_o  = 1'b1;
               end
            end
            ST_PARK: st_d = ST_PARK;
            ST_PWR: begin
               if (disc_i) begin
                  st_d   = ST_IDLE;
                  shut_o = 1'b1;
               end
            end
            default: st_d = ST_IDLE;
         endcase
      end
   end

   assign st_o = st_q;

endmodule

// File: rtl/poe_status_regs.sv
module poe_status_regs
   import poe_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       shut_i,
   input  logic       det_wr_i,
   input  logic [2:0] det_val_i,
   input  logic       cls_wr_i,
   input  logic [2:0] cls_val_i,
   input  logic       pwr_enter_i,
   input  logic       hp_i,
   output logic [2:0] det_stat_o,
   output logic [2:0] cls_stat_o,
   output logic       ilim_hi_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         det_stat_o <= DET_UNK;
         cls_stat_o <= CLS_UNK;
         ilim_hi_o  <= 1'b0;
      end else begin
         if (shut_i) begin
            det_stat_o <= DET_UNK;
            cls_stat_o <= CLS_UNK;
         end else begin
            if (det_wr_i) det_stat_o <= det_val_i;
            if (cls_wr_i) cls_stat_o <= cls_val_i;
         end
         if (pwr_enter_i) ilim_hi_o <= hp_i;
      end
   end

endmodule

// File: rtl/poe_icut_sel.sv
module poe_icut_sel #(
   parameter int ICUT_W    = 8,
   parameter int LSB_UA    = 3200,
   parameter bit POLICE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_i,
   input  logic [2:0]        cls_i,
   input  logic              hp_i,
   output logic [ICUT_W-1:0] icut_o
);

   // nominal cut currents in mA (supported current plus margin)
   localparam int MA_STD  = 366;
   localparam int MA_C1   = 95;
   localparam int MA_C2   = 166;
   localparam int MA_HP4  = 629;
   localparam logic [ICUT_W-1:0] CODE_STD = ICUT_W'((MA_STD * 1000) / LSB_UA);
   localparam logic [ICUT_W-1:0] CODE_C1  = ICUT_W'((MA_C1  * 1000) / LSB_UA);
   localparam logic [ICUT_W-1:0] CODE_C2  = ICUT_W'((MA_C2  * 1000) / LSB_UA);
   localparam logic [ICUT_W-1:0] CODE_HP4 = ICUT_W'((MA_HP4 * 1000) / LSB_UA);

   initial begin
      assert (LSB_UA > 0);
      assert (((MA_HP4 * 1000) / LSB_UA) < (1 << ICUT_W));
   end

   logic [ICUT_W-1:0] icut_q;

   generate
      if (POLICE_EN) begin : g_police
         logic [ICUT_W-1:0] code;
         always_comb begin
            unique case (cls_i)
               3'd1:    code = CODE_C1;
               3'd2:    code = CODE_C2;
               3'd4:    code = hp_i ? CODE_HP4 : CODE_STD;
               default: code = CODE_STD;
            endcase
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     icut_q <= CODE_STD;
            else if (upd_i) icut_q <= code;
         end
      end else begin : g_fixed
         logic unused_in;
         assign unused_in = upd_i ^ hp_i ^ (^cls_i) ^ clk ^ rst_n;
         assign icut_q    = CODE_STD;
      end
   endgenerate

   assign icut_o = icut_q;

endmodule

// File: rtl/poe_port_seq.sv
module poe_port_seq
   import poe_seq_pkg::*;
#(
   parameter int ICUT_W    = 8,
   parameter int LSB_UA    = 3200,
   parameter bit POLICE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode_i,
   input  logic              hp_i,
   input  logic              man_pwr_i,
   input  logic              det_done_i,
   input  logic [2:0]        det_res_i,
   input  logic              cls_done_i,
   input  logic [2:0]        cls_res_i,
   input  logic              mark_done_i,
   input  logic              disc_i,
   output logic              det_req_o,
   output logic              cls_req_o,
   output logic              mark_req_o,
   output logic              pwr_en_o,
   output logic [2:0]        det_stat_o,
   output logic [2:0]        cls_stat_o,
   output logic              cls_err_o,
   output logic [ICUT_W-1:0] icut_o,
   output logic              ilim_hi_o
);

   initial assert (ICUT_W >= 8);

   logic       chg, to_off;
   seq_st_e    st;
   logic       det_wr, cls_wr, icut_upd, pwr_enter, shut;
   logic [2:0] cls_val, icut_cls;

   poe_mode_track u_mode (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .chg_o(chg), .to_off_o(to_off)
   );

   poe_seq_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .chg_i(chg), .to_off_i(to_off),
      .man_pwr_i(man_pwr_i), .det_done_i(det_done_i), .det_res_i(det_res_i),
      .cls_done_i(cls_done_i), .cls_res_i(cls_res_i), .mark_done_i(mark_done_i),
      .disc_i(disc_i), .st_o(st), .det_wr_o(det_wr), .cls_wr_o(cls_wr),
      .cls_val_o(cls_val), .icut_upd_o(icut_upd), .icut_cls_o(icut_cls),
      .pwr_enter_o(pwr_enter), .shut_o(shut)
   );

   poe_status_regs u_stat (
      .clk(clk), .rst_n(rst_n), .shut_i(shut), .det_wr_i(det_wr), .det_val_i(det_res_i),
      .cls_wr_i(cls_wr), .cls_val_i(cls_val), .pwr_enter_i(pwr_enter), .hp_i(hp_i),
      .det_stat_o(det_stat_o), .cls_stat_o(cls_stat_o), .ilim_hi_o(ilim_hi_o)
   );

   poe_icut_sel #(.ICUT_W(ICUT_W), .LSB_UA(LSB_UA), .POLICE_EN(POLICE_EN)) u_icut (
      .clk(clk), .rst_n(rst_n), .upd_i(icut_upd), .cls_i(icut_cls), .hp_i(hp_i),
      .icut_o(icut_o)
   );

   assign det_req_o  = (st == ST_DET);
   assign cls_req_o  = (st == ST_CLS1) || (st == ST_CLS2);
   assign mark_req_o = (st == ST_MRK1) || (st == ST_MRK2);
   assign pwr_en_o   = (st == ST_PWR);
   assign cls_err_o  = (cls_stat_o == CLS_ERR);

endmodule

// File: rtl/poe_port_seq_chk.sv
module poe_port_seq_chk #(
   parameter int ICUT_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        mode_i,
   input logic              det_req_o,
   input logic              cls_req_o,
   input logic              mark_req_o,
   input logic              pwr_en_o,
   input logic [2:0]        det_stat_o,
   input logic [2:0]        cls_stat_o,
   input logic              cls_err_o,
   input logic [ICUT_W-1:0] icut_o
);

   AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      mode_i == 2'b00 |=> !(det_req_o || cls_req_o || mark_req_o || pwr_en_o)); // R2
   AST_SEMI_NO_PWR: assert property (@(posedge clk) disable iff (!rst_n)
      mode_i == 2'b10 |=> !pwr_en_o); // R6
   AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({det_req_o, cls_req_o, mark_req_o, pwr_en_o})); // R8
   AST_CLS_AFTER_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cls_req_o) && $past(mode_i) != 2'b01 |-> det_stat_o == 3'd4); // R5
   AST_PWR_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_en_o) |-> ($past(mode_i) == 2'b01 || $past(mode_i) == 2'b11)); // R7
   AST_PWR_HAS_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_en_o) |-> (cls_stat_o >= 3'd1 && cls_stat_o <= 3'd5)); // R11
   AST_ERR_NO_PWR: assert property (@(posedge clk) disable iff (!rst_n)
      cls_err_o |-> !pwr_en_o); // R9
   AST_ICUT_AUTO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(mode_i) != 2'b11 |-> $stable(icut_o)); // R10

endmodule

bind poe_port_seq poe_port_seq_chk #(.ICUT_W(ICUT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .det_req_o(det_req_o),
   .cls_req_o(cls_req_o), .mark_req_o(mark_req_o), .pwr_en_o(pwr_en_o),
   .det_stat_o(det_stat_o), .cls_stat_o(cls_stat_o), .cls_err_o(cls_err_o),
   .icut_o(icut_o)
);

// File: tb/poe_port_seq_bench.sv
module poe_port_seq_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode_i = 2'b00;
   logic       hp_i = 1'b0, man_pwr_i = 1'b0, det_done_i = 1'b0;
   logic [2:0] det_res_i = 3'd0, cls_res_i = 3'd0;
   logic       cls_done_i = 1'b0, mark_done_i = 1'b0, disc_i = 1'b0;
   logic       det_req_o, cls_req_o, mark_req_o, pwr_en_o, cls_err_o, ilim_hi_o;
   logic [2:0] det_stat_o, cls_stat_o;
   logic [7:0] icut_o;

   int errs = 0, checks = 0, exp_icut = 114;
   bit done = 1'b0;

   always #10 clk = ~clk;

   poe_port_seq u_poe_port_seq (.*);

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   function automatic int code_for(int c, bit hp);
      int ma;
      ma = (c == 1) ? 95 : (c == 2) ? 166 : (c == 4 && hp) ? 629 : 366;
      return (ma * 10) / 32;
   endfunction

   task automatic set_mode(logic [1:0] m);
      mode_i = m;
      tick();
   endtask

   task automatic idle_quiet(string tag);
      chk(tag, int'({det_req_o, cls_req_o, mark_req_o, pwr_en_o}), 0);
   endtask

   task automatic good_detect();
      tick();
      chk("R4 det_req", int'(det_req_o), 1);
      det_done_i = 1'b1; det_res_i = 3'd4;
      tick();
      det_done_i = 1'b0;
      chk("R5 cls_req after good", int'(cls_req_o), 1);
      chk("R4 det_stat good", int'(det_stat_o), 4);
   endtask

   task automatic cls_event(int c);
      cls_done_i = 1'b1; cls_res_i = 3'(c);
      tick();
      cls_done_i = 1'b0;
   endtask

   task automatic mark_event();
      mark_done_i = 1'b1;
      tick();
      mark_done_i = 1'b0;
   endtask

   task automatic powered_tail(bit hp);
      chk("R12 ilim latch", int'(ilim_hi_o), int'(hp));
      hp_i = ~hp;
      tick();
      chk("R12 ilim ignores change", int'(ilim_hi_o), int'(hp));
      hp_i = hp;
      disc_i = 1'b1;
      tick();
      disc_i = 1'b0;
      chk("R13 pwr off on disc", int'(pwr_en_o), 0);
      chk("R13 det_stat cleared", int'(det_stat_o), 0);
      chk("R13 cls_stat cleared", int'(cls_stat_o), 0);
   endtask

   task automatic run_auto(int c1, int c2, bit hp);
      hp_i = hp;
      good_detect();
      cls_event(c1);
      if (c1 < 4) begin
         chk("R7 power on", int'(pwr_en_o), 1);
         chk("R11 cls_stat", int'(cls_stat_o), c1 + 1);
         exp_icut = code_for(c1, hp);
         chk("R11 icut", int'(icut_o), exp_icut);
         powered_tail(hp);
      end else begin
         chk("R8 mark1", int'(mark_req_o), 1);
         chk("R8 no power yet", int'(pwr_en_o), 0);
         mark_event();
         chk("R8 second cls_req", int'(cls_req_o), 1);
         cls_event(c2);
         if (c2 == 4) begin
            chk("R8 mark2", int'(mark_req_o), 1);
            mark_event();
            chk("R8 power after mark2", int'(pwr_en_o), 1);
            exp_icut = code_for(4, hp);
            chk("R11 icut class4", int'(icut_o), exp_icut);
            chk("R11 cls_stat class4", int'(cls_stat_o), 5);
            powered_tail(hp);
         end else begin
            chk("R9 cls_stat error", int'(cls_stat_o), 6);
            chk("R9 cls_err", int'(cls_err_o), 1);
            chk("R9 no power", int'(pwr_en_o), 0);
            tick();
            chk("R9 back to detection", int'(det_req_o), 1);
            det_done_i = 1'b1; det_res_i = 3'd1;
            tick();
            det_done_i = 1'b0;
            chk("R4 bad detect no class", int'(cls_req_o), 0);
            chk("R4 det_stat open", int'(det_stat_o), 1);
         end
      end
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      idle_quiet("R1 outputs");
      chk("R1 det_stat", int'(det_stat_o), 0);
      chk("R1 cls_stat", int'(cls_stat_o), 0);
      chk("R1 icut", int'(icut_o), 114);
      chk("R1 ilim", int'(ilim_hi_o), 0);

      // R2 shutdown ignores commands and strobes
      for (int i = 0; i < 4; i++) begin
         man_pwr_i = 1'b1; det_done_i = 1'b1; det_res_i = 3'd4;
         cls_done_i = 1'b1; mark_done_i = 1'b1;
         tick();
         idle_quiet("R2 shutdown quiet");
         chk("R2 status untouched", int'(det_stat_o), 0);
      end
      man_pwr_i = 1'b0; det_done_i = 1'b0; cls_done_i = 1'b0; mark_done_i = 1'b0;

      // R7 R8 R9 R11 R12 R13 auto sweep
      set_mode(2'b11);
      for (int hp = 0; hp < 2; hp++)
         for (int c1 = 0; c1 < 5; c1++)
            if (c1 < 4) run_auto(c1, 0, bit'(hp));
            else for (int c2 = 0; c2 < 5; c2++) run_auto(c1, c2, bit'(hp));

      // R3 mode change while powered (auto to semi)
      good_detect();
      cls_event(0);
      exp_icut = code_for(0, 1'b0);
      chk("R7 powered before change", int'(pwr_en_o), 1);
      set_mode(2'b10);
      chk("R3 change drops power", int'(pwr_en_o), 0);
      chk("R3 non-off change keeps status", int'(cls_stat_o), 1);

      // R6 semi-auto sweep
      for (int c = 0; c < 5; c++) begin
         set_mode(2'b10);
         hp_i = 1'b1;
         good_detect();
         cls_event(c);
         for (int k = 0; k < 3; k++) begin
            idle_quiet("R6 parked");
            chk("R6 cls_stat", int'(cls_stat_o), c + 1);
            chk("R6 icut unchanged", int'(icut_o), exp_icut);
            tick();
         end
         set_mode(2'b00);
         chk("R3 off clears det", int'(det_stat_o), 0);
         chk("R3 off clears cls", int'(cls_stat_o), 0);
      end

      // R10 manual sweep
      for (int c = 0; c < 5; c++) begin
         set_mode(2'b01);
         tick();
         idle_quiet("R10 waits for command");
         man_pwr_i = 1'b1;
         tick();
         man_pwr_i = 1'b0;
         chk("R10 cls_req on command", int'(cls_req_o), 1);
         cls_event(c);
         chk("R10 power on", int'(pwr_en_o), 1);
         chk("R10 cls_stat", int'(cls_stat_o), c + 1);
         chk("R10 icut unchanged", int'(icut_o), exp_icut);
         set_mode(2'b00);
         chk("R3 off drops power", int'(pwr_en_o), 0);
         chk("R3 off clears cls", int'(cls_stat_o), 0);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errs++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

endmodule